// File: doc/BRIEF.md
# SMBus Block Transfer Data Path

This block is the block-transfer part of an SMBus host controller. It sits between a small software register window and a byte-level bus engine. Software sets up the slave address, the command, the byte count and the payload. Writing the start bit then launches a block write or a block read. The block sends the header bytes and the data to the engine over a valid/ready byte stream. It takes received bytes back over a second valid/ready stream. For each requested receive byte it also presents the command code that the engine uses to decide between ACK and NACK.

There are two data modes. In buffered mode, a 32-entry byte store is filled or drained in one go through a single data port. The port index moves forward on each access and returns to zero whenever the control register is read. In stepped mode, the sequencer stops after every data byte and raises a byte-done flag. It waits until software writes a one to that flag, which gives software time to supply or collect the byte through a one-byte holding register. Buffered mode is used only for SMBus-form transfers. I2C-form transfers always run stepped.

The sequencer has nine states:
- SQ_IDLE goes to SQ_ADDR on start.
- SQ_ADDR goes to SQ_CMD when the engine accepts the address byte.
- SQ_CMD goes to one of four states: SQ_CNT for an SMBus write, SQ_TXD for an I2C write, SQ_RCNT for an SMBus read, or SQ_RXD for an I2C read.
- SQ_CNT goes to SQ_TXD.
- SQ_TXD and SQ_RXD loop on themselves in buffered mode. After the final byte they go to SQ_FIN. In stepped mode they go to SQ_WAIT after each byte.
- SQ_RCNT goes to SQ_RXD on a legal count. On an illegal count it goes to SQ_FIN.
- SQ_WAIT goes back to SQ_TXD or SQ_RXD when byte-done is cleared. If every byte has moved, it goes to SQ_FIN instead.
- SQ_FIN goes to SQ_IDLE.

Top module: `smb_block_path`

## Requirements
- R1: After reset every register reads 0x00, the status reads 0x00, and tx_valid and rx_ready are low.
- R2: Register 2 (AUX) keeps only bit 1, the buffered-mode enable. A read returns 0x02 when that bit is set and 0x00 when it is clear, whatever else was written.
- R3: A read of register 1 (CTRL) returns the port index to zero, so the next port read returns buffer entry 0.
- R4: In buffered mode, a write to register 6 (PORT) stores at the index and advances it. A read returns the entry at the index and advances it. A read at an index not below COUNT (register 3) returns 0x00 and leaves the index where it is.
- R5: Writing CTRL with bit 6 set starts a transfer; bit 0 selects read (1) and bit 1 selects I2C form. The engine first gets {ADDR[6:0], rw}, then the command byte. An SMBus write then sends the count, clamped to the range 1..32, followed by that many data bytes. An I2C write sends the data bytes without a count.
- R6: In an SMBus block read, the first received byte is the count. It is written into COUNT, and the data bytes that follow go into the buffer.
- R7: A received count of 0 or above 32 sets status bit 3 and ends the transfer without requesting any data byte.
- R8: In stepped mode, status bit 7 is set after each data byte. No byte moves on either stream until software writes 1 to bit 7.
- R9: During a receive, byte_cmd reads 0x14 for SMBus bytes and 0x18 for I2C bytes. For the final data byte it reads 0x34 (SMBus) or 0x38 (I2C), so that the engine NACKs that byte.
- R10: An I2C read sends address bit 0 as 0 and takes the command byte from DATA1 (register 4) instead of CMD (register 5).
- R11: I2C-form transfers run stepped even when AUX bit 1 is set, and the data port then reaches the holding register.
- R12: Status bit 0 is high while a transfer runs. Status bit 1 sets when the transfer ends. Writing 1 to bits 1, 3 or 7 of status clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Register write strobe |
| sw_rd | input | 1 | Register read strobe; read side effects apply at the clock edge |
| sw_addr | input | 3 | Register select |
| sw_wdata | input | 8 | Register write data |
| sw_rdata | output | 8 | Register read data for sw_addr |
| tx_valid | output | 1 | Byte offered to the bus engine |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Engine accepts tx_data |
| rx_ready | output | 1 | Block requests a received byte |
| rx_valid | input | 1 | Engine presents a received byte |
| rx_data | input | 8 | Received byte |
| byte_cmd | output | 8 | Command code for the requested receive byte |

## Verification
The main function is exercised with several transfer shapes: buffered SMBus writes and reads, a write with a zero count that has to be clamped, reads that return illegal counts of 0 and 33, a stepped SMBus write, and a stepped I2C read with the buffered enable set. The write patterns separate count clamping from the use of the raw count. The read patterns separate the last-byte code from the middle-byte code, and the SMBus header from the I2C header. Engine stalls on both streams vary how the handshakes are timed. During stepped waits, the bench watches both streams to show that nothing moves while byte-done is pending.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
    localparam logic [2:0] RA_STAT  = 3'd0;
    localparam logic [2:0] RA_CTRL  = 3'd1;
    localparam logic [2:0] RA_AUX   = 3'd2;
    localparam logic [2:0] RA_COUNT = 3'd3;
    localparam logic [2:0] RA_DATA1 = 3'd4;
    localparam logic [2:0] RA_CMD   = 3'd5;
    localparam logic [2:0] RA_PORT  = 3'd6;
    localparam logic [2:0] RA_ADDR  = 3'd7;

    localparam int unsigned ST_BDONE = 7;
    localparam int unsigned ST_PERR  = 3;
    localparam int unsigned ST_DONE  = 1;
    localparam int unsigned ST_BUSY  = 0;

    localparam int unsigned CT_GO  = 6;
    localparam int unsigned CT_I2C = 1;
    localparam int unsigned CT_DIR = 0;

    localparam int unsigned AUX_BUF = 1;

    localparam logic [7:0] CODE_BLK       = 8'h14;
    localparam logic [7:0] CODE_BLK_LAST  = 8'h34;
    localparam logic [7:0] CODE_I2C       = 8'h18;
    localparam logic [7:0] CODE_I2C_LAST  = 8'h38;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_ADDR, SQ_CMD, SQ_CNT, SQ_TXD,
        SQ_RCNT, SQ_RXD, SQ_WAIT, SQ_FIN
    } sq_state_e;
endpackage

// File: rtl/smb_blk_mem.sv
module smb_blk_mem #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned W     = 8,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata_a = store[raddr_a];
    assign rdata_b = store[raddr_b];
endmodule

// File: rtl/smb_blk_index.sv
module smb_blk_index #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned IW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_acc,
    input  logic          rd_acc,
    input  logic [7:0]    limit,
    output logic [IW-1:0] idx,
    output logic          wr_ok,
    output logic          rd_ok
);
    assign wr_ok = (32'(idx) < DEPTH);
    assign rd_ok = wr_ok && (32'(idx) < 32'(limit));

    always_ff @(posedge clk) begin
        if (!rst_n)                                      idx <= '0;
        else if (clr)                                    idx <= '0;
        else if ((wr_acc && wr_ok) || (rd_acc && rd_ok)) idx <= idx + 1'b1;
    end

    AST_IDX_CEIL: assert property (@(posedge clk) disable iff (!rst_n) 32'(idx) <= DEPTH); // R4
    AST_IDX_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !rd_ok && !clr && !wr_acc) |=> $stable(idx)); // R4
endmodule

// File: rtl/smb_blk_seq.sv
module smb_blk_seq
    import smb_blk_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned IW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_dir,
    input  logic          go_i2c,
    input  logic          buf_en,
    input  logic [6:0]    addr7,
    input  logic [7:0]    cmd_reg,
    input  logic [7:0]    data1_reg,
    input  logic [7:0]    count_reg,
    input  logic [7:0]    hold_reg,
    input  logic [7:0]    mem_rdata,
    input  logic          bd_flag,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          rx_ready,
    output logic [7:0]    byte_cmd,
    output logic          busy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          hold_we,
    output logic          cnt_we,
    output logic          set_bd,
    output logic          set_done,
    output logic          set_perr
);
    sq_state_e     state, nstate;
    logic          dir_q, i2c_q, bufm_q;
    logic [IW-1:0] len_q, xcnt;
    logic          last_rx, last_tx, cnt_ok;

    function automatic logic [IW-1:0] clamp_len(input logic [7:0] c);
        if (c == 8'd0)             return IW'(1);
        else if (32'(c) > DEPTH)   return IW'(DEPTH);
        else                       return IW'(c);
    endfunction

    assign last_rx  = (xcnt == len_q - 1'b1);
    assign last_tx  = (IW'(xcnt + 1'b1) == len_q);
    assign cnt_ok   = (rx_data != 8'd0) && (32'(rx_data) <= DEPTH);
    assign mem_addr = xcnt[AW-1:0];

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            dir_q  <= 1'b0;
            i2c_q  <= 1'b0;
            bufm_q <= 1'b0;
            len_q  <= '0;
            xcnt   <= '0;
        end else begin
            state <= nstate;
            if (state == SQ_IDLE && go) begin
                dir_q  <= go_dir;
                i2c_q  <= go_i2c;
                bufm_q <= buf_en && !go_i2c;
                len_q  <= clamp_len(count_reg);
                xcnt   <= '0;
            end
            if (state == SQ_RCNT && rx_valid && cnt_ok) len_q <= IW'(rx_data);
            if ((state == SQ_TXD && tx_ready) || (state == SQ_RXD && rx_valid))
                xcnt <= xcnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            SQ_IDLE: if (go) nstate = SQ_ADDR;
            SQ_ADDR: if (tx_ready) nstate = SQ_CMD;
            SQ_CMD:  if (tx_ready) begin
                if (dir_q) nstate = i2c_q ? SQ_RXD : SQ_RCNT;
                else       nstate = i2c_q ? SQ_TXD : SQ_CNT;
            end
            SQ_CNT:  if (tx_ready) nstate = SQ_TXD;
            SQ_TXD:  if (tx_ready) begin
                if (!bufm_q)      nstate = SQ_WAIT;
                else if (last_tx) nstate = SQ_FIN;
            end
            SQ_RCNT: if (rx_valid) nstate = cnt_ok ? SQ_RXD : SQ_FIN;
            SQ_RXD:  if (rx_valid) begin
                if (!bufm_q)      nstate = SQ_WAIT;
                else if (last_rx) nstate = SQ_FIN;
            end
            SQ_WAIT: if (!bd_flag) begin
                if (xcnt == len_q) nstate = SQ_FIN;
                else               nstate = dir_q ? SQ_RXD : SQ_TXD;
            end
            SQ_FIN:  nstate = SQ_IDLE;
            default: nstate = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        rx_ready = 1'b0;
        byte_cmd = 8'h00;
        mem_we   = 1'b0;
        hold_we  = 1'b0;
        cnt_we   = 1'b0;
        set_bd   = 1'b0;
        set_perr = 1'b0;
        set_done = 1'b0;
        busy     = (state != SQ_IDLE);
        unique case (state)
            SQ_ADDR: begin
                tx_valid = 1'b1;
                tx_data  = {addr7, dir_q && !i2c_q};
            end
            SQ_CMD: begin
                tx_valid = 1'b1;
                tx_data  = (dir_q && i2c_q) ? data1_reg : cmd_reg;
            end
            SQ_CNT: begin
                tx_valid = 1'b1;
                tx_data  = 8'(len_q);
            end
            SQ_TXD: begin
                tx_valid = 1'b1;
                tx_data  = bufm_q ? mem_rdata : hold_reg;
                set_bd   = !bufm_q && tx_ready;
            end
            SQ_RCNT: begin
                rx_ready = 1'b1;
                byte_cmd = CODE_BLK;
                cnt_we   = rx_valid && cnt_ok;
                set_perr = rx_valid && !cnt_ok;
            end
            SQ_RXD: begin
                rx_ready = 1'b1;
                if (last_rx) byte_cmd = i2c_q ? CODE_I2C_LAST : CODE_BLK_LAST;
                else         byte_cmd = i2c_q ? CODE_I2C : CODE_BLK;
                mem_we   = rx_valid && bufm_q;
                hold_we  = rx_valid && !bufm_q;
                set_bd   = rx_valid && !bufm_q;
            end
            SQ_FIN:  set_done = 1'b1;
            default: ;
        endcase
    end

    AST_LAST_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rx_valid && byte_cmd[5]) |=> !rx_ready); // R9
    AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready)); // R5
endmodule

// File: rtl/smb_block_path.sv
module smb_block_path
    import smb_blk_pkg::*;
#(
    parameter int unsigned DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic       sw_rd,
    input  logic [2:0] sw_addr,
    input  logic [7:0] sw_wdata,
    output logic [7:0] sw_rdata,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       rx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic [7:0] byte_cmd
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned IW = $clog2(DEPTH + 1);

    logic [6:0]    addr_q;
    logic [7:0]    cmd_q, data1_q, count_q, hold_q;
    logic          aux_buf_q, ctrl_dir_q, ctrl_i2c_q;
    logic          bd_q, perr_q, done_q;
    logic          busy, go, port_buf;
    logic          sw_port_wr, sw_port_rd, sw_ctrl_rd;
    logic [IW-1:0] idx;
    logic          wr_ok, rd_ok;
    logic [AW-1:0] seq_mem_addr;
    logic          seq_mem_we, seq_hold_we, seq_cnt_we;
    logic          set_bd, set_done, set_perr;
    logic [7:0]    mem_rd_a, mem_rd_b;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata;

    assign port_buf   = aux_buf_q && !ctrl_i2c_q;
    assign sw_port_wr = sw_wr && (sw_addr == RA_PORT);
    assign sw_port_rd = sw_rd && (sw_addr == RA_PORT);
    assign sw_ctrl_rd = sw_rd && (sw_addr == RA_CTRL);
    assign go         = sw_wr && (sw_addr == RA_CTRL) && sw_wdata[CT_GO] && !busy;

    assign mem_we    = seq_mem_we || (sw_port_wr && port_buf && !busy && wr_ok);
    assign mem_waddr = seq_mem_we ? seq_mem_addr : idx[AW-1:0];
    assign mem_wdata = seq_mem_we ? rx_data : sw_wdata;

    smb_blk_mem #(.DEPTH(DEPTH), .W(8), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(idx[AW-1:0]), .rdata_a(mem_rd_a),
        .raddr_b(seq_mem_addr), .rdata_b(mem_rd_b)
    );

    smb_blk_index #(.DEPTH(DEPTH), .IW(IW)) u_index (
        .clk(clk), .rst_n(rst_n), .clr(sw_ctrl_rd),
        .wr_acc(sw_port_wr && port_buf && !busy),
        .rd_acc(sw_port_rd && port_buf),
        .limit(count_q), .idx(idx), .wr_ok(wr_ok), .rd_ok(rd_ok)
    );

    smb_blk_seq #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go),
        .go_dir(sw_wdata[CT_DIR]), .go_i2c(sw_wdata[CT_I2C]), .buf_en(aux_buf_q),
        .addr7(addr_q), .cmd_reg(cmd_q), .data1_reg(data1_q), .count_reg(count_q),
        .hold_reg(hold_q), .mem_rdata(mem_rd_b), .bd_flag(bd_q),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_ready(rx_ready), .byte_cmd(byte_cmd),
        .busy(busy), .mem_addr(seq_mem_addr), .mem_we(seq_mem_we),
        .hold_we(seq_hold_we), .cnt_we(seq_cnt_we),
        .set_bd(set_bd), .set_done(set_done), .set_perr(set_perr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            cmd_q      <= '0;
            data1_q    <= '0;
            count_q    <= '0;
            hold_q     <= '0;
            aux_buf_q  <= 1'b0;
            ctrl_dir_q <= 1'b0;
            ctrl_i2c_q <= 1'b0;
            bd_q       <= 1'b0;
            perr_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            if (sw_wr) begin
                unique case (sw_addr)
                    RA_STAT: begin
                        if (sw_wdata[ST_BDONE]) bd_q   <= 1'b0;
                        if (sw_wdata[ST_PERR])  perr_q <= 1'b0;
                        if (sw_wdata[ST_DONE])  done_q <= 1'b0;
                    end
                    RA_CTRL: if (!busy) begin
                        ctrl_dir_q <= sw_wdata[CT_DIR];
                        ctrl_i2c_q <= sw_wdata[CT_I2C];
                    end
                    RA_AUX:   aux_buf_q <= sw_wdata[AUX_BUF];
                    RA_COUNT: count_q   <= sw_wdata;
                    RA_DATA1: data1_q   <= sw_wdata;
                    RA_CMD:   cmd_q     <= sw_wdata;
                    RA_PORT:  if (!port_buf) hold_q <= sw_wdata;
                    RA_ADDR:  addr_q    <= sw_wdata[6:0];
                    default: ;
                endcase
            end
            if (seq_cnt_we)  count_q <= rx_data;
            if (seq_hold_we) hold_q  <= rx_data;
            if (set_bd)      bd_q    <= 1'b1;
            if (set_perr)    perr_q  <= 1'b1;
            if (set_done)    done_q  <= 1'b1;
        end
    end

    always_comb begin
        sw_rdata = 8'h00;
        unique case (sw_addr)
            RA_STAT: begin
                sw_rdata[ST_BDONE] = bd_q;
                sw_rdata[ST_PERR]  = perr_q;
                sw_rdata[ST_DONE]  = done_q;
                sw_rdata[ST_BUSY]  = busy;
            end
            RA_CTRL: begin
                sw_rdata[CT_I2C] = ctrl_i2c_q;
                sw_rdata[CT_DIR] = ctrl_dir_q;
            end
            RA_AUX:   sw_rdata[AUX_BUF] = aux_buf_q;
            RA_COUNT: sw_rdata = count_q;
            RA_DATA1: sw_rdata = data1_q;
            RA_CMD:   sw_rdata = cmd_q;
            RA_PORT:  sw_rdata = port_buf ? (rd_ok ? mem_rd_a : 8'h00) : hold_q;
            RA_ADDR:  sw_rdata = {1'b0, addr_q};
            default:  sw_rdata = 8'h00;
        endcase
    end

    AST_STALL_ON_BDONE: assert property (@(posedge clk) disable iff (!rst_n)
        bd_q |-> (!tx_valid && !rx_ready)); // R8
    AST_PERR_FROM_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr_q) |-> $past(rx_valid && rx_ready)); // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (!busy && $past(busy))); // R12
endmodule

// File: tb/smb_block_path_bench.sv
module smb_block_path_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_wr, sw_rd;
    logic [2:0] sw_addr;
    logic [7:0] sw_wdata, sw_rdata;
    logic       tx_valid, tx_ready;
    logic [7:0] tx_data;
    logic       rx_ready, rx_valid;
    logic [7:0] rx_data;
    logic [7:0] byte_cmd;

    int checks = 0;
    int errors = 0;
    int eng_cnt = 0;
    int tx_seen = 0;
    int rx_seen = 0;
    byte unsigned exp_tx[$];
    byte unsigned exp_code[$];
    byte unsigned rx_src[$];
    string tx_tag = "R5";

    always #5 clk = ~clk;

    smb_block_path u_smb_block_path (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .byte_cmd(byte_cmd)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // engine model: compared against the expected byte streams on every clock
    always @(negedge clk) begin
        eng_cnt++;
        tx_ready = rst_n && (eng_cnt % 3 != 1);
        rx_valid = 1'b0;
        if (rx_ready && rx_src.size() > 0 && (eng_cnt % 4 != 2)) begin
            rx_valid = 1'b1;
            rx_data  = rx_src[0];
        end
        #1;
        if (tx_valid && tx_ready) begin
            tx_seen++;
            if (exp_tx.size() > 0) begin
                check(tx_data == exp_tx[0], tx_tag, tx_data, exp_tx[0]);
                void'(exp_tx.pop_front());
            end else check(0, "R5 unexpected tx byte", tx_data, 0);
        end
        if (rx_valid && rx_ready) begin
            rx_seen++;
            void'(rx_src.pop_front());
            if (exp_code.size() > 0) begin
                check(byte_cmd == exp_code[0], "R9 byte_cmd", byte_cmd, exp_code[0]);
                void'(exp_code.pop_front());
            end else check(0, "R7 unexpected rx byte", rx_data, 0);
        end
    end

    task automatic sw_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic sw_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); sw_rd = 1'b1; sw_addr = a; #1 d = sw_rdata;
        @(negedge clk); sw_rd = 1'b0;
    endtask

    task automatic wait_stat(input int bitpos);
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            sw_read(3'd0, s);
            if (s[bitpos]) break;
        end
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        sw_read(a, v);
        check(v == e, tag, v, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int base;
        sw_wr = 0; sw_rd = 0; sw_addr = 0; sw_wdata = 0; rx_valid = 0; rx_data = 0; tx_ready = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        #1 check(!tx_valid && !rx_ready, "R1 engine idle", {tx_valid, rx_ready}, 0);
        expect_reg(3'd0, 8'h00, "R1 status");
        expect_reg(3'd3, 8'h00, "R1 count");
        expect_reg(3'd2, 8'h00, "R1 aux");

        // R2 aux readback
        sw_write(3'd2, 8'hFF);
        expect_reg(3'd2, 8'h02, "R2 aux bit1 only");
        sw_write(3'd2, 8'hFD);
        expect_reg(3'd2, 8'h00, "R2 aux cleared");
        sw_write(3'd2, 8'h02);

        // R4 / R3 buffered port
        sw_write(3'd3, 8'd3);
        sw_read(3'd1, v);
        sw_write(3'd6, 8'h11); sw_write(3'd6, 8'h22); sw_write(3'd6, 8'h33);
        sw_read(3'd1, v);
        expect_reg(3'd6, 8'h11, "R4 port entry0");
        expect_reg(3'd6, 8'h22, "R4 port entry1");
        expect_reg(3'd6, 8'h33, "R4 port entry2");
        expect_reg(3'd6, 8'h00, "R4 past count");
        expect_reg(3'd6, 8'h00, "R4 past count again");
        sw_read(3'd1, v);
        expect_reg(3'd6, 8'h11, "R3 index reset by ctrl read");

        // R5 / R12 buffered SMBus write
        sw_write(3'd7, 8'h50); sw_write(3'd5, 8'hA5);
        tx_tag = "R5 smbus write stream";
        exp_tx = '{8'hA0, 8'hA5, 8'h03, 8'h11, 8'h22, 8'h33};
        sw_write(3'd1, 8'h40);
        expect_reg(3'd0, 8'h01, "R12 busy during transfer");
        wait_stat(1);
        expect_reg(3'd0, 8'h02, "R12 done set");
        check(exp_tx.size() == 0, "R5 all bytes sent", exp_tx.size(), 0);
        sw_write(3'd0, 8'h02);
        expect_reg(3'd0, 8'h00, "R12 done cleared");

        // R5 clamp of zero count
        sw_write(3'd3, 8'd0);
        sw_read(3'd1, v);
        sw_write(3'd6, 8'h5A);
        exp_tx = '{8'hA0, 8'hA5, 8'h01, 8'h5A};
        sw_write(3'd1, 8'h40);
        wait_stat(1);
        check(exp_tx.size() == 0, "R5 clamped count", exp_tx.size(), 0);
        sw_write(3'd0, 8'h02);

        // R6 / R9 buffered SMBus read
        tx_tag = "R6 smbus read header";
        exp_tx = '{8'hA1, 8'hA5};
        rx_src = '{8'h04, 8'hD0, 8'hD1, 8'hD2, 8'hD3};
        exp_code = '{8'h14, 8'h14, 8'h14, 8'h14, 8'h34};
        sw_write(3'd1, 8'h41);
        wait_stat(1);
        check(exp_code.size() == 0, "R9 all codes seen", exp_code.size(), 0);
        expect_reg(3'd3, 8'h04, "R6 count stored");
        sw_read(3'd1, v);
        expect_reg(3'd6, 8'hD0, "R6 data0");
        expect_reg(3'd6, 8'hD1, "R6 data1");
        expect_reg(3'd6, 8'hD2, "R6 data2");
        expect_reg(3'd6, 8'hD3, "R6 data3");
        expect_reg(3'd6, 8'h00, "R4 read beyond count");
        sw_write(3'd0, 8'h02);

        // R7 illegal counts
        for (int k = 0; k < 2; k++) begin
            exp_tx = '{8'hA1, 8'hA5};
            rx_src = '{(k == 0) ? 8'h00 : 8'h21, 8'hEE};
            exp_code = '{8'h14};
            base = rx_seen;
            sw_write(3'd1, 8'h41);
            wait_stat(1);
            repeat (6) @(negedge clk);
            check(rx_seen - base == 1, "R7 no data requested", rx_seen - base, 1);
            expect_reg(3'd0, 8'h0A, "R7 protocol error flag");
            sw_write(3'd0, 8'h0A);
            rx_src.delete();
        end

        // R8 stepped SMBus write
        sw_write(3'd2, 8'h00);
        sw_write(3'd3, 8'd2);
        sw_write(3'd6, 8'hF0);
        tx_tag = "R8 stepped write stream";
        exp_tx = '{8'hA0, 8'hA5, 8'h02, 8'hF0, 8'hF1};
        base = tx_seen;
        sw_write(3'd1, 8'h40);
        wait_stat(7);
        repeat (8) @(negedge clk);
        check(tx_seen - base == 4, "R8 stalled after byte", tx_seen - base, 4);
        sw_write(3'd6, 8'hF1);
        sw_write(3'd0, 8'h80);
        wait_stat(7);
        check(tx_seen - base == 5, "R8 second byte", tx_seen - base, 5);
        sw_write(3'd0, 8'h80);
        wait_stat(1);
        expect_reg(3'd0, 8'h02, "R8 finished after ack");
        sw_write(3'd0, 8'h02);

        // R10 / R11 stepped I2C read with buffer enable set
        sw_write(3'd2, 8'h02);
        sw_write(3'd4, 8'h3C);
        sw_write(3'd3, 8'd2);
        tx_tag = "R10 i2c read header";
        exp_tx = '{8'hA0, 8'h3C};
        rx_src = '{8'hE0, 8'hE1};
        exp_code = '{8'h18, 8'h38};
        base = rx_seen;
        sw_write(3'd1, 8'h43);
        wait_stat(7);
        repeat (8) @(negedge clk);
        check(rx_seen - base == 1, "R8 read stalled", rx_seen - base, 1);
        expect_reg(3'd6, 8'hE0, "R11 holding byte 0");
        sw_write(3'd0, 8'h80);
        wait_stat(7);
        expect_reg(3'd6, 8'hE1, "R11 holding byte 1");
        sw_write(3'd0, 8'h80);
        wait_stat(1);
        check(exp_tx.size() == 0 && exp_code.size() == 0, "R10 streams complete",
              exp_tx.size() + exp_code.size(), 0);
        expect_reg(3'd0, 8'h02, "R12 done after i2c read");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule